// File: doc/BRIEF.md
# Watchdog Timer with Sleep Wake-Up

This block is a watchdog counter for a small processor subsystem. It advances only on a tick-enable strobe that comes from its own slow time base, so the time it measures does not depend on the system clock rate. Each tick first passes through a power-of-two postscaler. The divided ticks then drive a binary counter toward overflow. Software restarts the measurement with a clear strobe, called "kick" here, and must do so before the counter wraps.

When the counter overflows, the result depends on the power state at that moment. With the device running, the block drives a system reset pulse that lasts a fixed number of ticks. With the device in sleep or idle, it gives a one-cycle wake request instead, so execution can resume where it stopped. Each overflow leaves sticky cause flags in a small status word. These flags record that the watchdog fired and, for a wake, which low-power mode was active. A watchdog reset does not clear them. Only an explicit software clear or the block's own reset does.

A configuration bit that is fixed at build time turns the watchdog on or off for good. No runtime input can override it.

Top module: `wdt_sleepwake`

## Requirements
- R1: With `cfg_enable`=1 and no kick, the overflow event occurs on tick number 2^(`post_sel`+CNT_W) counted from the last clear. It never occurs earlier.
- R2: A `kick` strobe clears both the postscaler and the main counter in that cycle. The next full period is then counted from zero.
- R3: An overflow while both `in_sleep` and `in_idle` are 0 drives `sys_reset` high from the next cycle. It stays high for exactly RST_TICKS further ticks, then drops.
- R4: An overflow while `in_sleep` or `in_idle` is 1 drives `wake_req` high for exactly one cycle and does not raise `sys_reset`.
- R5: Every overflow sets `status[0]`, the watchdog-cause flag, in the following cycle.
- R6: An overflow that wakes the device sets `status[1]` when `in_sleep` is 1. It sets `status[2]` when only `in_idle` is 1. Sleep takes priority when both are 1.
- R7: With `cfg_enable`=0, no overflow, reset pulse or wake request ever occurs, whatever the other inputs do.
- R8: `post_sel` is a 3-bit field that selects a divide ratio of 2^`post_sel`, from 1 up to 128.
- R9: Any change of `post_sel` clears the postscaler and the main counter on the next clock edge, so a fresh full period starts.
- R10: Status flags persist through the reset pulse. Only `flag_clr` or `rst_n` clears them. A flag set in the same cycle as `flag_clr` wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe from the independent time base |
| cfg_enable | input | 1 | Fixed configuration bit, 1 = watchdog always on |
| kick | input | 1 | Software clear strobe |
| in_sleep | input | 1 | Device is in sleep |
| in_idle | input | 1 | Device is in idle |
| post_sel | input | 3 | Postscaler select, ratio 2^post_sel |
| flag_clr | input | 1 | Software clear of the status flags |
| sys_reset | output | 1 | System reset pulse |
| wake_req | output | 1 | One-cycle wake request |
| status | output | 3 | Cause flags: [0] watchdog, [1] was sleeping, [2] was idle |

## Verification
The assertions check, on every cycle, the relations between neighbouring stages:
- a kick, a select change or a disabled watchdog leaves the counters at zero;
- each overflow raises the reset or the wake request that matches the power state, and sets the cause flag;
- the wake request lasts one cycle;
- the cause flag is sticky.

Only the bench scenarios can show the absolute timing, because they count ticks across whole periods:
- the exact timeout tick for every postscaler ratio;
- the length of the reset pulse;
- the restart after a mid-period ratio change;
- the flag encodings left by sleep and idle wake-ups.

// File: rtl/wdt_pkg.sv
// Shared constants for the watchdog: status bit positions and the
// postscaler width derived from the select width.
package wdt_pkg;
    localparam int ST_CAUSE = 0;   // watchdog caused the event
    localparam int ST_SLEEP = 1;   // device was in sleep at wake
    localparam int ST_IDLE  = 2;   // device was in idle at wake
    localparam int ST_W     = 3;

    // Postscaler counter width for a given select width.
    function automatic int ps_width(input int sel_w);
        return (1 << sel_w) - 1;
    endfunction
endpackage

// File: rtl/wdt_postscale.sv
// Power-of-two divider on the independent tick strobe.
// Assumes: tick_en is a one-cycle strobe. A change of sel is detected
// against a registered copy and clears the divider.
module wdt_postscale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick_en,
    input  logic             kick,
    input  logic [SEL_W-1:0] sel,
    output logic             sel_chg,
    output logic             post_tick
);
    localparam int PS_W = wdt_pkg::ps_width(SEL_W);

    logic [PS_W-1:0]  pcnt;
    logic [PS_W-1:0]  mask;
    logic [SEL_W-1:0] sel_q;
    logic             clear;

    // Low-order mask: bit i is set when i < sel.
    always_comb begin
        for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(sel));
    end

    assign sel_chg   = (sel != sel_q);
    assign clear     = kick | sel_chg | ~en;
    assign post_tick = tick_en & ~clear & ((pcnt & mask) == mask);

    // Remember the select so that a change can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel;
    end

    // Advance the divider on each tick; any clear condition zeroes it.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pcnt <= '0;
        else if (tick_en)    pcnt <= pcnt + 1'b1;
    end

    // R9
    sel_change_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (pcnt == '0));

    // R2
    kick_clears_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (pcnt == '0));
endmodule

// File: rtl/wdt_counter.sv
// Main watchdog counter. Advances on each postscaled tick and flags
// overflow when it wraps from all ones.
// Assumes: step is never high in a cycle where restart is high.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic step,
    input  logic restart,
    output logic ovf
);
    logic [CNT_W-1:0] cnt;

    assign ovf = step & (cnt == {CNT_W{1'b1}});

    // Count divided ticks; restart or disable returns the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) cnt <= '0;
        else if (step)                cnt <= cnt + 1'b1;
    end

    // R2
    kick_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R7
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((cnt == '0) && !ovf));
endmodule

// File: rtl/wdt_response.sv
// Turns an overflow into a reset pulse or a wake request, according to
// the power state, and keeps the sticky cause flags.
// Assumes: ovf is a single-cycle event, at least two cycles apart.
module wdt_response #(
    parameter int RST_TICKS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   ovf,
    input  logic                   in_sleep,
    input  logic                   in_idle,
    input  logic                   flag_clr,
    output logic                   sys_reset,
    output logic                   wake_req,
    output logic [wdt_pkg::ST_W-1:0] status
);
    import wdt_pkg::*;
    localparam int RC_W = $clog2(RST_TICKS + 1);

    logic [RC_W-1:0] rst_cnt;
    logic            low_pwr;

    assign low_pwr   = in_sleep | in_idle;
    assign sys_reset = (rst_cnt != '0);

    // Reset pulse length counted in ticks; an active-mode overflow reloads it.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rst_cnt <= '0;
        else if (ovf && !low_pwr)            rst_cnt <= RC_W'(RST_TICKS);
        else if (tick_en && rst_cnt != '0)   rst_cnt <= rst_cnt - 1'b1;
    end

    // One-cycle wake request for an overflow in sleep or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) wake_req <= 1'b0;
        else        wake_req <= ovf & low_pwr;
    end

    // Sticky cause flags; setting wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= flag_clr ? '0 : status;
            if (ovf) begin
                status[ST_CAUSE] <= 1'b1;
                if (in_sleep)     status[ST_SLEEP] <= 1'b1;
                else if (in_idle) status[ST_IDLE]  <= 1'b1;
            end
        end
    end

    // R3
    reset_after_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !low_pwr) |=> sys_reset);

    // R4
    wake_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && low_pwr && !sys_reset) |=> (wake_req && !sys_reset));

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R5
    cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> status[ST_CAUSE]);

    // R10
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[ST_CAUSE] && !flag_clr) |=> status[ST_CAUSE]);
endmodule

// File: rtl/wdt_sleepwake.sv
// Watchdog top: postscaler, counter and overflow response.
// Assumes: cfg_enable is static after reset; tick_en comes from an
// independent slow time base already brought into this clock domain.
module wdt_sleepwake #(
    parameter int CNT_W     = 8,
    parameter int SEL_W     = 3,
    parameter int RST_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cfg_enable,
    input  logic             kick,
    input  logic             in_sleep,
    input  logic             in_idle,
    input  logic [SEL_W-1:0] post_sel,
    input  logic             flag_clr,
    output logic             sys_reset,
    output logic             wake_req,
    output logic [2:0]       status
);
    logic sel_chg;
    logic post_tick;
    logic ovf;

    wdt_postscale #(.SEL_W(SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .tick_en(tick_en),
        .kick(kick), .sel(post_sel), .sel_chg(sel_chg), .post_tick(post_tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cfg_enable), .step(post_tick),
        .restart(kick | sel_chg), .ovf(ovf)
    );

    wdt_response #(.RST_TICKS(RST_TICKS)) u_rsp (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ovf(ovf),
        .in_sleep(in_sleep), .in_idle(in_idle), .flag_clr(flag_clr),
        .sys_reset(sys_reset), .wake_req(wake_req), .status(status)
    );

    // R7
    disabled_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!sys_reset && !wake_req));
endmodule

// File: tb/wdt_sleepwake_bench.sv
module wdt_sleepwake_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 3;
    localparam int RST_TICKS  = 2;
    localparam int WATCHDOG   = 150000;

    logic clk = 0, rst_n = 0, tick_en = 0, cfg_enable = 1, kick = 0;
    logic in_sleep = 0, in_idle = 0, flag_clr = 0;
    logic [2:0] post_sel = 0;
    logic sys_reset, wake_req;
    logic [2:0] status;

    int checks = 0, errors = 0;
    bit done = 0;
    bit seen_event = 0;

    wdt_sleepwake #(.CNT_W(CNT_W), .SEL_W(3), .RST_TICKS(RST_TICKS)) u_wdt_sleepwake (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_enable(cfg_enable),
        .kick(kick), .in_sleep(in_sleep), .in_idle(in_idle), .post_sel(post_sel),
        .flag_clr(flag_clr), .sys_reset(sys_reset), .wake_req(wake_req), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (sys_reset || wake_req) seen_event = 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One tick strobe, then one quiet cycle; returns at a negedge.
    task automatic tick();
        @(negedge clk) tick_en = 1;
        @(negedge clk) tick_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_kick();
        @(negedge clk) kick = 1;
        @(negedge clk) kick = 0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
    endtask

    task automatic set_sel(input int s);
        @(negedge clk) post_sel = 3'(s);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("reset sys_reset", sys_reset, 0);
        check("reset wake_req", wake_req, 0);
        check("reset status", status, 0);

        // R1 R3 R5 R8 R10: sweep every postscaler ratio in active mode
        for (int s = 0; s < 8; s++) begin
            int n;
            n = 1 << (s + CNT_W);
            set_sel(s);
            pulse_clr();
            pulse_kick();
            ticks(n - 1);
            check($sformatf("R1 R8 no early timeout sel=%0d", s), sys_reset, 0);
            tick();
            check($sformatf("R1 R8 timeout sel=%0d", s), sys_reset, 1);
            check($sformatf("R5 cause flag sel=%0d", s), status, 1);
            ticks(RST_TICKS - 1);
            check($sformatf("R3 pulse held sel=%0d", s), sys_reset, 1);
            tick();
            check($sformatf("R3 pulse ended sel=%0d", s), sys_reset, 0);
            check($sformatf("R10 flag kept sel=%0d", s), status, 1);
        end

        // R2: kicks before the period ends keep the reset away
        set_sel(0);
        pulse_clr();
        pulse_kick();
        ticks(7);
        pulse_kick();
        ticks(7);
        check("R2 kick prevents timeout", sys_reset, 0);
        check("R2 no flag after kick", status, 0);
        tick();
        check("R2 full period after kick", sys_reset, 1);
        ticks(RST_TICKS);

        // R9: ratio change mid-period restarts counting at the new ratio
        pulse_kick();
        ticks(5);
        set_sel(1);
        ticks(15);
        check("R9 no timeout after change", sys_reset, 0);
        tick();
        check("R9 timeout after full new period", sys_reset, 1);
        ticks(RST_TICKS);

        // R4 R6: sleep wake
        set_sel(0);
        pulse_clr();
        in_sleep = 1;
        pulse_kick();
        ticks(8);
        check("R4 sleep wake pulse", wake_req, 1);
        check("R4 sleep no reset", sys_reset, 0);
        check("R6 sleep flags", status, 3);
        @(negedge clk);
        check("R4 wake one cycle", wake_req, 0);

        // R4 R6: idle wake
        in_sleep = 0; in_idle = 1;
        pulse_clr();
        pulse_kick();
        ticks(8);
        check("R4 idle wake pulse", wake_req, 1);
        check("R4 idle no reset", sys_reset, 0);
        check("R6 idle flags", status, 5);

        // R6: both states, sleep wins
        in_sleep = 1;
        pulse_clr();
        check("R10 flag_clr clears", status, 0);
        pulse_kick();
        ticks(8);
        check("R6 sleep priority", status, 3);
        in_sleep = 0; in_idle = 0;

        // R10: set wins over clear in the same cycle
        pulse_kick();
        ticks(7);
        @(negedge clk) begin tick_en = 1; flag_clr = 1; end
        @(negedge clk) begin tick_en = 0; flag_clr = 0; end
        check("R10 set wins over clear", status, 1);
        ticks(RST_TICKS);

        // R7: disabled watchdog never fires
        @(negedge clk) rst_n = 0; cfg_enable = 0;
        @(negedge clk) rst_n = 1;
        @(negedge clk) seen_event = 0;
        ticks(200);
        check("R7 disabled no reset/wake", int'(seen_event), 0);
        check("R7 disabled no flags", status, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule